// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial-bus protocol engine and a byte-wide nonvolatile array. The engine loads a start address. It then passes each received data byte as a one-cycle strobe and reports how the transaction ended. A stop that falls in the slot right after a data byte's acknowledge is a valid stop. Any other stop is an invalid stop. The buffered bytes go into a page latch, and each buffered byte sets its own flag. Only the low offset bits of the address counter advance, so any excess bytes wrap round and overwrite the start of the same page.

A valid stop with at least one flagged byte starts an internal write cycle. The block raises `busy` for a fixed number of clocks. While `busy` is high, the engine refuses device selection, so a master can poll until it gets an acknowledge. Inside that window the flagged locations drain to the array write port, one per clock, in ascending offset order. Bytes that were never flagged are not written. The array itself lies outside the block and starts with every byte at 0xFF.

A stop in any other slot throws the buffered bytes away. So does a new address load. When the write-control level is high, data bytes are refused.

Top module: `pageCommitUnit`

## Requirements
- R1: After reset, `busy` and `memWe` are low and `addrCnt` is zero.
- R2: A pulse on `addrLoad` while idle sets `addrCnt` to `addrIn` one clock later.
- R3: A byte strobe accepted while idle with `wrCtrl` low moves the five low bits of `addrCnt` on by one, modulo 32, and leaves bits 11..5 unchanged. After offset 31 the counter moves to offset 0 of the same page.
- R4: A `stopValid` pulse while idle with at least one buffered byte raises `busy` one clock later. `busy` then stays high for exactly BUSY_CYCLES clocks.
- R5: During a commit, `memWe` is high for exactly one clock per buffered offset. The writes come in ascending offset order, starting the clock after `busy` rises. Each write goes to the page given by `addrCnt` bits 11..5 and carries the byte most recently latched at that offset. No other location is written, so those locations keep their earlier content.
- R6: A `stopOther` pulse discards the buffered bytes. No write and no busy period follow, and a later `stopValid` with nothing buffered does nothing.
- R7: While `wrCtrl` is high, byte strobes are ignored: `addrCnt` is unchanged and nothing is latched. A `stopValid` with nothing buffered starts no write cycle.
- R8: While `busy` is high, the inputs `addrLoad`, `byteStb`, `stopValid` and `stopOther` have no effect. `addrCnt` holds its value, no extra write occurs, and the busy length is unchanged.
- R9: When the commit ends, `addrCnt` points to the location after the last accepted byte, wrapping inside the page.
- R10: An `addrLoad` clears all buffered bytes, so a `stopValid` that follows with no new byte starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrLoad | input | 1 | Load start address pulse |
| addrIn | input | ADDR_W | Start address to load |
| byteStb | input | 1 | Data byte strobe |
| byteData | input | DATA_W | Data byte |
| stopValid | input | 1 | Stop seen in the slot right after a data acknowledge |
| stopOther | input | 1 | Stop seen in any other slot |
| wrCtrl | input | 1 | Write-control level; high blocks data bytes |
| memWe | output | 1 | Array write enable |
| memAddr | output | ADDR_W | Array write address |
| memWdata | output | DATA_W | Array write data |
| busy | output | 1 | Internal write cycle in progress; the engine refuses selection |
| addrCnt | output | ADDR_W | Internal address counter |

## Verification
The results for address loads and accepted bytes show on `addrCnt` one clock after the input. `busy` rises one clock after a valid stop. The first write strobe is present in that same clock and lands in the array at the next edge, with one more write per clock after that. The bench drives every input on the falling edge and samples on the next falling edge, so each check reads the value that the single register stage between them has just produced. The bench measures busy length by counting the falling edges on which `busy` is high. It checks write order against a log filled on each rising edge where `memWe` is high.

// File: rtl/pwc_pkg.sv
package pwcPkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_COMMIT = 1'b1
  } pwcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic takeByte;
    logic dropAll;
    logic drainOne;
  } pwcStrobe_t;

endpackage

// File: rtl/pwc_ctrl.sv
module pwcCtrl
  import pwcPkg::*;
#(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrLoad,
  input  logic       byteStb,
  input  logic       stopValid,
  input  logic       stopOther,
  input  logic       wrCtrl,
  input  logic       anyValid,
  output pwcStrobe_t strobe,
  output logic       busy
);

  localparam int TMR_W = $clog2(BUSY_CYCLES + 1);

  pwcState_e         state;
  logic [TMR_W-1:0]  timer;
  logic              commitGo;

  always_comb begin
    strobe   = '0;
    commitGo = 1'b0;
    if (state == ST_IDLE) begin
      strobe.loadAddr = addrLoad;
      strobe.takeByte = byteStb & ~wrCtrl & ~addrLoad;
      strobe.dropAll  = stopOther;
      commitGo        = stopValid & anyValid & ~addrLoad & ~stopOther;
    end else begin
      strobe.drainOne = anyValid;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (commitGo) begin
            state <= ST_COMMIT;
            timer <= TMR_W'(BUSY_CYCLES - 1);
          end
        end
        default: begin
          if (timer == '0) state <= ST_IDLE;
          else             timer <= timer - 1'b1;
        end
      endcase
    end
  end

  assign busy = (state == ST_COMMIT);

endmodule

// File: rtl/pwc_data.sv
module pwcData
  import pwcPkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwcStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] byteData,
  output logic              anyValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] addrCnt
);

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_BYTES-1:0] validMask;
  logic [PAGE_BYTES-1:0] maskNext;
  logic [DATA_W-1:0]     slotData [PAGE_BYTES];
  logic [OFF_W-1:0]      pickIdx;
  logic [OFF_W-1:0]      curOff;
  logic [PAGE_W-1:0]     curPage;

  assign curOff  = addrCnt[OFF_W-1:0];
  assign curPage = addrCnt[ADDR_W-1:OFF_W];

  // one latch register per page offset
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSlot
    logic [DATA_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotQ <= '0;
      else if (strobe.takeByte && curOff == OFF_W'(g))
        slotQ <= byteData;
    end
    assign slotData[g] = slotQ;
  end

  // lowest flagged offset drains first
  always_comb begin
    pickIdx = '0;
    for (int i = PAGE_BYTES - 1; i >= 0; i--)
      if (validMask[i]) pickIdx = OFF_W'(i);
  end

  always_comb begin
    maskNext = validMask;
    if (strobe.drainOne) maskNext[pickIdx] = 1'b0;
    if (strobe.takeByte) maskNext[curOff]  = 1'b1;
    if (strobe.dropAll || strobe.loadAddr) maskNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMask <= '0;
      addrCnt   <= '0;
    end else begin
      validMask <= maskNext;
      if (strobe.loadAddr)
        addrCnt <= addrIn;
      else if (strobe.takeByte)
        addrCnt <= {curPage, OFF_W'(curOff + 1'b1)};
    end
  end

  assign anyValid = |validMask;
  assign memAddr  = {curPage, pickIdx};
  assign memWdata = slotData[pickIdx];

endmodule

// File: rtl/page_commit_unit.sv
module pageCommitUnit
  import pwcPkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              byteStb,
  input  logic [DATA_W-1:0] byteData,
  input  logic              stopValid,
  input  logic              stopOther,
  input  logic              wrCtrl,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              busy,
  output logic [ADDR_W-1:0] addrCnt
);

  pwcStrobe_t strobe;
  logic       anyValid;

  pwcCtrl #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .addrLoad (addrLoad),
    .byteStb  (byteStb),
    .stopValid(stopValid),
    .stopOther(stopOther),
    .wrCtrl   (wrCtrl),
    .anyValid (anyValid),
    .strobe   (strobe),
    .busy     (busy)
  );

  pwcData #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .addrIn  (addrIn),
    .byteData(byteData),
    .anyValid(anyValid),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .addrCnt (addrCnt)
  );

  assign memWe = strobe.drainOne;

endmodule

// File: rtl/page_commit_chk.sv
module pageCommitChk #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 500000
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrLoad,
  input logic [ADDR_W-1:0] addrIn,
  input logic              byteStb,
  input logic              stopValid,
  input logic              wrCtrl,
  input logic              memWe,
  input logic              busy,
  input logic [ADDR_W-1:0] addrCnt
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 2) + 1;

  logic [CNT_W-1:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(addrLoad) && !$past(busy)) |-> (addrCnt == $past(addrIn)));

  // R3
  offset_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(byteStb) && !$past(busy) && !$past(wrCtrl) && !$past(addrLoad)) |->
      ((addrCnt[ADDR_W-1:OFF_W] == $past(addrCnt[ADDR_W-1:OFF_W])) &&
       (addrCnt[OFF_W-1:0] == OFF_W'($past(addrCnt[OFF_W-1:0]) + 1'b1))));

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopValid));

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == CNT_W'(BUSY_CYCLES)));

  // R5
  write_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R7
  wc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrCtrl) && !$past(addrLoad)) |-> $stable(addrCnt));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(addrCnt));

endmodule

bind pageCommitUnit pageCommitChk #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES),
  .BUSY_CYCLES(BUSY_CYCLES)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .addrLoad (addrLoad),
  .addrIn   (addrIn),
  .byteStb  (byteStb),
  .stopValid(stopValid),
  .wrCtrl   (wrCtrl),
  .memWe    (memWe),
  .busy     (busy),
  .addrCnt  (addrCnt)
);

// File: tb/tb_pageCommitUnit.sv
module tb_pageCommitUnit;

  localparam int AW = 12;
  localparam int DW = 8;
  localparam int PB = 32;
  localparam int BC = 48;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          addrLoad = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          byteStb = 1'b0;
  logic [DW-1:0] byteData = '0;
  logic          stopValid = 1'b0;
  logic          stopOther = 1'b0;
  logic          wrCtrl = 1'b0;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          busy;
  logic [AW-1:0] addrCnt;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pageCommitUnit #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .BUSY_CYCLES(BC)
  ) dut (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
    .byteStb(byteStb), .byteData(byteData), .stopValid(stopValid),
    .stopOther(stopOther), .wrCtrl(wrCtrl), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .busy(busy), .addrCnt(addrCnt)
  );

  // array model, all bytes start at 0xFF
  logic [DW-1:0] arr [1 << AW];
  logic [AW-1:0] wrLog [64];
  int wrCount = 0;
  int busyRun = 0;
  int lastBusyLen = 0;

  initial for (int i = 0; i < (1 << AW); i++) arr[i] = 8'hFF;

  always @(posedge clk) begin
    if (rstN && memWe) begin
      arr[memAddr] <= memWdata;
      if (wrCount < 64) wrLog[wrCount] <= memAddr;
      wrCount <= wrCount + 1;
    end
  end

  always @(negedge clk) begin
    if (busy) busyRun <= busyRun + 1;
    else if (busyRun != 0) begin
      lastBusyLen <= busyRun;
      busyRun     <= 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic loadAddr(input logic [AW-1:0] a);
    addrLoad = 1'b1; addrIn = a;
    @(negedge clk);
    addrLoad = 1'b0;
  endtask

  task automatic sendByte(input logic [DW-1:0] d);
    byteStb = 1'b1; byteData = d;
    @(negedge clk);
    byteStb = 1'b0;
  endtask

  task automatic stopV();
    stopValid = 1'b1;
    @(negedge clk);
    stopValid = 1'b0;
  endtask

  task automatic stopO();
    stopOther = 1'b1;
    @(negedge clk);
    stopOther = 1'b0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tReset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "memWe", int'(memWe), 0);
    chk("R1", "addrCnt", int'(addrCnt), 0);
  endtask

  task automatic tLoad();
    loadAddr(12'h123);
    chk("R2", "addrCnt after load", int'(addrCnt), 'h123);
  endtask

  task automatic tSingle();
    int base;
    loadAddr(12'h245);
    sendByte(8'hA5);
    chk("R3", "addrCnt after byte", int'(addrCnt), 'h246);
    base = wrCount;
    stopV();
    chk("R4", "busy one clock after stop", int'(busy), 1);
    @(negedge clk);
    chk("R5", "first write one clock later", wrCount - base, 1);
    waitIdle();
    chk("R4", "busy length", lastBusyLen, BC);
    chk("R5", "write count", wrCount - base, 1);
    chk("R5", "written byte", int'(arr['h245]), 'hA5);
    chk("R5", "neighbour below untouched", int'(arr['h244]), 'hFF);
    chk("R5", "neighbour above untouched", int'(arr['h246]), 'hFF);
    chk("R9", "addrCnt after commit", int'(addrCnt), 'h246);
  endtask

  task automatic tWrap();
    int base;
    loadAddr(12'h03E);
    sendByte(8'h11);
    sendByte(8'h22);
    chk("R3", "wrap to page start", int'(addrCnt), 'h020);
    sendByte(8'h33);
    sendByte(8'h44);
    base = wrCount;
    stopV();
    waitIdle();
    chk("R5", "wrap write count", wrCount - base, 4);
    chk("R5", "order 0", int'(wrLog[base]), 'h020);
    chk("R5", "order 1", int'(wrLog[base+1]), 'h021);
    chk("R5", "order 2", int'(wrLog[base+2]), 'h03E);
    chk("R5", "order 3", int'(wrLog[base+3]), 'h03F);
    chk("R3", "data at 03E", int'(arr['h03E]), 'h11);
    chk("R3", "data at 020", int'(arr['h020]), 'h33);
    chk("R3", "next page untouched", int'(arr['h040]), 'hFF);
    chk("R3", "previous page untouched", int'(arr['h01F]), 'hFF);
    chk("R9", "addrCnt after wrap commit", int'(addrCnt), 'h022);
  endtask

  task automatic tOverwrite();
    int base;
    loadAddr(12'h100);
    for (int i = 0; i < 34; i++) sendByte(8'(i + 1));
    base = wrCount;
    stopV();
    waitIdle();
    chk("R5", "full page write count", wrCount - base, 32);
    chk("R5", "offset 0 holds newest", int'(arr['h100]), 33);
    chk("R5", "offset 1 holds newest", int'(arr['h101]), 34);
    chk("R5", "offset 31", int'(arr['h11F]), 32);
    chk("R9", "addrCnt after roll", int'(addrCnt), 'h102);
  endtask

  task automatic tStopOther();
    int base;
    loadAddr(12'h300);
    sendByte(8'h5A);
    base = wrCount;
    stopO();
    chk("R6", "no busy after other stop", int'(busy), 0);
    stopV();
    chk("R6", "no busy after late valid stop", int'(busy), 0);
    idleCyc(3);
    chk("R6", "no writes", wrCount - base, 0);
    chk("R6", "array unchanged", int'(arr['h300]), 'hFF);
  endtask

  task automatic idleCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tWrCtrl();
    int base;
    loadAddr(12'h400);
    wrCtrl = 1'b1;
    sendByte(8'h77);
    chk("R7", "addrCnt held", int'(addrCnt), 'h400);
    base = wrCount;
    stopV();
    chk("R7", "no busy", int'(busy), 0);
    wrCtrl = 1'b0;
    idleCyc(3);
    chk("R7", "no writes", wrCount - base, 0);
    chk("R7", "array unchanged", int'(arr['h400]), 'hFF);
  endtask

  task automatic tBusyIgnore();
    int base;
    loadAddr(12'h500);
    sendByte(8'h01);
    base = wrCount;
    stopV();
    loadAddr(12'h600);
    sendByte(8'h99);
    stopO();
    stopV();
    chk("R8", "addrCnt held while busy", int'(addrCnt), 'h501);
    waitIdle();
    chk("R8", "busy length unchanged", lastBusyLen, BC);
    chk("R8", "single write", wrCount - base, 1);
    chk("R8", "committed byte", int'(arr['h500]), 'h01);
    chk("R8", "ignored byte not written", int'(arr['h501]), 'hFF);
    chk("R8", "ignored load not written", int'(arr['h600]), 'hFF);
    stopV();
    chk("R8", "no second commit", int'(busy), 0);
  endtask

  task automatic tReload();
    int base;
    loadAddr(12'h700);
    sendByte(8'h12);
    loadAddr(12'h710);
    base = wrCount;
    stopV();
    chk("R10", "no busy after reload", int'(busy), 0);
    idleCyc(3);
    chk("R10", "no writes", wrCount - base, 0);
    chk("R10", "array unchanged", int'(arr['h700]), 'hFF);
    chk("R10", "addrCnt reloaded", int'(addrCnt), 'h710);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLoad();
    tSingle();
    tWrap();
    tOverwrite();
    tStopOther();
    tWrCtrl();
    tBusyIgnore();
    tReload();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule